// File: doc/BRIEF.md
# CRC-Guarded SPI Register Slave

This block is an SPI slave (mode 0) that gives a host access to a small register file. It can protect traffic in both directions with an 8-bit CRC. The generator polynomial is x^8 + x^2 + x + 1. The CRC register is loaded with all ones when each frame starts and is fed the payload bits MSB first. The SPI pins are oversampled in the system clock domain.

After reset the slave uses short 16-bit frames with no CRC. Setting the CRC-enable bit switches it to 32-bit frames, which the slave checks on receive and extends on transmit.

If a frame arrives with a wrong CRC byte, the slave does not execute it and raises a sticky error flag. While that flag is up, every register write is dropped except the one that clears the flag. Reads that carry a correct CRC are still answered.

Top module: `crc_spi_regslave`

## Requirements
- R1: In CRC mode, the last byte the slave shifts out in each frame is the CRC of the 24 payload bits before it. The CRC uses polynomial 0x07, starts from 0xFF and takes the bits MSB first.
- R2: A CRC-mode frame is 32 bits, sent MSB first. Bits 31:24 are the opcode (0x01 = write, 0x02 = read, any other value = no operation). Bits 23:16 are the register address, bits 15:8 are the data and bits 7:0 are the CRC. A write with a correct CRC updates the addressed register.
- R3: With CRC mode off, a frame is 16 bits. Bits 15:14 are the opcode (01 = write, 10 = read). Bits 13:8 are the address and bits 7:0 are the data.
- R4: The value read by a read command comes back in the first byte of the next frame. The rest of the payload is zero.
- R5: A complete CRC-mode frame whose CRC byte is wrong is not executed, and it sets the error flag `crc_err`.
- R6: While `crc_err` is set, writes are ignored, except a write of 1 to bit 0 of the status register.
- R7: While `crc_err` is set, a read with a correct CRC is served. A read with a wrong CRC is not served, so the previously read value is returned.
- R8: A correct-CRC write with bit 0 set, sent to the status register at address 0x00, clears `crc_err`. The same write with a wrong CRC does not clear it. After the clear, register writes take effect again.
- R9: A frame ended by CS_n rising after any bit count other than the frame length is discarded. It changes no register and does not set the error flag.
- R10: Bit 0 of the config register at address 0x01 enables CRC mode. The new mode applies from the next frame.
- R11: Reading the status register returns the error flag in bit 0 and zeros in the other bits.
- R12: After reset, `crc_err` is 0, MISO is 0, CRC mode is off and all registers read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, 0 when deselected |
| crc_err | output | 1 | Sticky CRC error flag |

## Verification
A command takes effect about four clock cycles after CS_n rises: two synchronizer stages, one edge-detect stage and one register update. The bench waits twelve cycles after deselect before it checks `crc_err` or sends the next frame. A read result is due in the frame after the read, so every read check sends a second frame and checks the response captured there. MISO changes about three cycles after a falling SCLK edge. SCLK half-periods are eight cycles, and MISO is sampled at the end of the low phase, before the rising edge.

// File: rtl/crc_spi_pkg.sv
package crc_spi_pkg;
  localparam int FRAME_LONG   = 32;
  localparam int FRAME_SHORT  = 16;
  localparam int PAYLOAD_BITS = 24;
  localparam logic [7:0] CRC_POLY = 8'h07;
  localparam logic [7:0] CRC_INIT = 8'hFF;

  localparam logic [7:0] OPC_WRITE = 8'h01;
  localparam logic [7:0] OPC_READ  = 8'h02;
  localparam logic [1:0] SOP_WRITE = 2'b01;
  localparam logic [1:0] SOP_READ  = 2'b10;

  localparam logic [7:0] ADDR_STATUS = 8'h00;
  localparam logic [7:0] ADDR_CFG    = 8'h01;

  typedef enum logic [1:0] {CMD_NOP, CMD_WRITE, CMD_READ} cmd_kind_e;

  typedef struct packed {
    cmd_kind_e  kind;
    logic [7:0] addr;
    logic [7:0] data;
  } cmd_t;

  // one serial CRC step, MSB-first
  function automatic logic [7:0] crc8_bit(logic [7:0] c, logic b);
    logic fb;
    fb = c[7] ^ b;
    return {c[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
  endfunction

  // CRC over a whole payload word, preset applied here
  function automatic logic [7:0] crc8_word(logic [PAYLOAD_BITS-1:0] w);
    logic [7:0] c;
    c = CRC_INIT;
    for (int i = PAYLOAD_BITS - 1; i >= 0; i--) c = crc8_bit(c, w[i]);
    return c;
  endfunction

  function automatic cmd_t decode_cmd(logic long_mode, logic [31:0] w);
    cmd_t c;
    if (long_mode) begin
      c.addr = w[23:16];
      c.data = w[15:8];
      if (w[31:24] == OPC_WRITE)     c.kind = CMD_WRITE;
      else if (w[31:24] == OPC_READ) c.kind = CMD_READ;
      else                           c.kind = CMD_NOP;
    end else begin
      c.addr = {2'b00, w[13:8]};
      c.data = w[7:0];
      if (w[15:14] == SOP_WRITE)     c.kind = CMD_WRITE;
      else if (w[15:14] == SOP_READ) c.kind = CMD_READ;
      else                           c.kind = CMD_NOP;
    end
    return c;
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_fall,
  output logic cs_rise,
  output logic mosi_s
);
  logic [STAGES:0] sclk_p;
  logic [STAGES:0] cs_p;
  logic [STAGES-1:0] mosi_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
    end else begin
      sclk_p <= {sclk_p[STAGES-1:0], spi_sclk};
      cs_p   <= {cs_p[STAGES-1:0], spi_cs_n};
      mosi_p <= {mosi_p[STAGES-2:0], spi_mosi};
    end
  end

  assign sclk_rise = sclk_p[STAGES-1] & ~sclk_p[STAGES];
  assign sclk_fall = ~sclk_p[STAGES-1] & sclk_p[STAGES];
  assign cs_fall   = ~cs_p[STAGES-1] & cs_p[STAGES];
  assign cs_rise   = cs_p[STAGES-1] & ~cs_p[STAGES];
  assign mosi_s    = mosi_p[STAGES-1];
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import crc_spi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk_rise,
  input  logic        sclk_fall,
  input  logic        cs_fall,
  input  logic        cs_rise,
  input  logic        mosi_s,
  input  logic        crc_en,
  input  logic [7:0]  tx_byte,
  output logic        frame_done,
  output logic        long_mode,
  output logic        crc_ok,
  output logic [5:0]  bit_cnt,
  output logic [31:0] rx_word,
  output logic        spi_miso
);
  localparam logic [5:0] CNT_MAX = 6'h3F;
  localparam logic [5:0] CRC_SPAN = 6'(PAYLOAD_BITS);

  logic        frame_open;
  logic [7:0]  crc_acc;
  logic [31:0] rx_sh;
  logic [31:0] tx_sh;
  logic [PAYLOAD_BITS-1:0] tx_payload;

  assign tx_payload = {tx_byte, 16'h0000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_open <= 1'b0;
      bit_cnt    <= '0;
      crc_acc    <= CRC_INIT;
      rx_sh      <= '0;
      tx_sh      <= '0;
      long_mode  <= 1'b0;
    end else if (cs_fall) begin
      frame_open <= 1'b1;
      bit_cnt    <= '0;
      crc_acc    <= CRC_INIT;
      long_mode  <= crc_en;
      tx_sh      <= crc_en ? {tx_payload, crc8_word(tx_payload)} : {tx_byte, 24'h000000};
    end else if (cs_rise) begin
      frame_open <= 1'b0;
    end else if (frame_open) begin
      if (sclk_rise) begin
        rx_sh <= {rx_sh[30:0], mosi_s};
        if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 6'd1;
        if (bit_cnt < CRC_SPAN) crc_acc <= crc8_bit(crc_acc, mosi_s);
      end
      if (sclk_fall && bit_cnt != 6'd0) tx_sh <= {tx_sh[30:0], 1'b0};
    end
  end

  assign frame_done = cs_rise & frame_open;
  assign crc_ok     = (crc_acc == rx_sh[7:0]);
  assign rx_word    = rx_sh;
  assign spi_miso   = frame_open & tx_sh[31];

  // R1: every frame starts from the preset and a zero count
  p_crc_preset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (crc_acc == CRC_INIT) && (bit_cnt == 6'd0));

  // R4: outgoing first byte is the read-back value at frame start
  p_tx_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> tx_sh[31:24] == $past(tx_byte));
endmodule

// File: rtl/crc_cmd_exec.sv
module crc_cmd_exec
  import crc_spi_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_done,
  input  logic        long_mode,
  input  logic        crc_ok,
  input  logic [5:0]  bit_cnt,
  input  logic [31:0] rx_word,
  output logic        crc_en,
  output logic        crc_err,
  output logic [7:0]  rd_data
);
  localparam int NUM_SCR = NUM_REGS - 2;

  cmd_t cmd;
  logic len_ok, abort_evt, crc_bad_evt, accept;
  logic addr_hit, wr_evt, wr_blocked, rd_evt, clear_evt;
  logic crc_en_q, crc_err_q;
  logic [7:0] rd_q, rd_mux;
  logic [NUM_SCR-1:0][7:0] scratch_q;
  logic [NUM_SCR-1:0] scr_we;

  assign cmd         = decode_cmd(long_mode, rx_word);
  assign len_ok      = long_mode ? (bit_cnt == 6'(FRAME_LONG)) : (bit_cnt == 6'(FRAME_SHORT));
  assign abort_evt   = frame_done & ~len_ok;
  assign crc_bad_evt = frame_done & len_ok & long_mode & ~crc_ok;
  assign accept      = frame_done & len_ok & (~long_mode | crc_ok);
  assign addr_hit    = cmd.addr < 8'(NUM_REGS);
  assign wr_evt      = accept & (cmd.kind == CMD_WRITE) & ~crc_err_q & addr_hit;
  assign wr_blocked  = accept & (cmd.kind == CMD_WRITE) & crc_err_q;
  assign rd_evt      = accept & (cmd.kind == CMD_READ);
  assign clear_evt   = wr_blocked & (cmd.addr == ADDR_STATUS) & cmd.data[0];

  for (genvar g = 0; g < NUM_SCR; g++) begin : g_scr_we
    assign scr_we[g] = wr_evt & (cmd.addr == 8'(g + 2));
  end

  always_comb begin
    rd_mux = 8'h00;
    if (cmd.addr == ADDR_STATUS)   rd_mux = {7'b0, crc_err_q};
    else if (cmd.addr == ADDR_CFG) rd_mux = {7'b0, crc_en_q};
    else begin
      for (int i = 0; i < NUM_SCR; i++)
        if (cmd.addr == 8'(i + 2)) rd_mux = scratch_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_err_q <= 1'b0;
      crc_en_q  <= 1'b0;
      rd_q      <= 8'h00;
      scratch_q <= '0;
    end else begin
      if (crc_bad_evt)    crc_err_q <= 1'b1;
      else if (clear_evt) crc_err_q <= 1'b0;
      if (wr_evt && cmd.addr == ADDR_CFG) crc_en_q <= cmd.data[0];
      if (rd_evt) rd_q <= rd_mux;
      for (int i = 0; i < NUM_SCR; i++)
        if (scr_we[i]) scratch_q[i] <= cmd.data;
    end
  end

  assign crc_en  = crc_en_q;
  assign crc_err = crc_err_q;
  assign rd_data = rd_q;

  // R5: a bad frame raises the flag and changes nothing else
  p_bad_crc_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    crc_bad_evt |=> crc_err_q && $stable(scratch_q) && $stable(crc_en_q) && $stable(rd_q));

  // R6: locked writes leave the register file untouched
  p_locked_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> $stable(scratch_q) && $stable(crc_en_q));

  // R8: the clear command drops the flag
  p_clear_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |=> !crc_err_q);

  // R9: a frame of the wrong length is discarded
  p_abort_discard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> $stable(crc_err_q) && $stable(scratch_q) && $stable(crc_en_q) && $stable(rd_q));
endmodule

// File: rtl/crc_spi_regslave.sv
module crc_spi_regslave #(
  parameter int NUM_REGS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic crc_err
);
  logic sclk_rise, sclk_fall, cs_fall, cs_rise, mosi_s;
  logic frame_done, long_mode, crc_ok, crc_en;
  logic [5:0] bit_cnt;
  logic [31:0] rx_word;
  logic [7:0] rd_data;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .mosi_s(mosi_s)
  );

  spi_frame_engine u_engine (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .mosi_s(mosi_s), .crc_en(crc_en),
    .tx_byte(rd_data), .frame_done(frame_done), .long_mode(long_mode),
    .crc_ok(crc_ok), .bit_cnt(bit_cnt), .rx_word(rx_word), .spi_miso(spi_miso)
  );

  crc_cmd_exec #(.NUM_REGS(NUM_REGS)) u_exec (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .long_mode(long_mode),
    .crc_ok(crc_ok), .bit_cnt(bit_cnt), .rx_word(rx_word), .crc_en(crc_en),
    .crc_err(crc_err), .rd_data(rd_data)
  );
endmodule

// File: tb/crc_spi_regslave_tb.sv
module crc_spi_regslave_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic miso, err;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  crc_spi_regslave dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .crc_err(err)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // byte-wise CRC, restated independently
  function automatic logic [7:0] ref_crc(input logic [23:0] p);
    logic [7:0] c;
    c = 8'hFF;
    for (int b = 2; b >= 0; b--) begin
      c = c ^ p[b*8 +: 8];
      for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

  function automatic logic [31:0] lf(input logic [7:0] op, input logic [7:0] a, input logic [7:0] d, input bit bad);
    logic [23:0] p;
    p = {op, a, d};
    return {p, ref_crc(p) ^ (bad ? 8'h5A : 8'h00)};
  endfunction

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input int nbits, input logic [31:0] tx, output logic [31:0] rx);
    rx = '0;
    cs_n = 1'b0;
    waitn(8);
    for (int i = 0; i < nbits; i++) begin
      mosi = tx[nbits-1-i];
      waitn(8);
      rx = {rx[30:0], miso};
      sclk = 1'b1;
      waitn(8);
      sclk = 1'b0;
    end
    waitn(8);
    cs_n = 1'b1;
    mosi = 1'b0;
    waitn(12);
  endtask

  task automatic lwrite(input logic [7:0] a, input logic [7:0] d, input bit bad);
    logic [31:0] rx;
    xfer(32, lf(8'h01, a, d, bad), rx);
  endtask

  // read then no-op frame; response checked for CRC (R1) and zero fill (R4)
  task automatic lread(input logic [7:0] a, input bit bad, output logic [7:0] v);
    logic [31:0] rx;
    xfer(32, lf(8'h02, a, 8'h00, bad), rx);
    xfer(32, lf(8'h00, 8'h00, 8'h00, 1'b0), rx);
    v = rx[31:24];
    check(rx[7:0] == ref_crc(rx[31:8]), "R1 response crc", {24'h0, rx[7:0]}, {24'h0, ref_crc(rx[31:8])});
    check(rx[23:8] == 16'h0, "R4 zero fill", {16'h0, rx[23:8]}, 32'h0);
  endtask

  task automatic sread(input logic [5:0] a, output logic [7:0] v);
    logic [31:0] rx;
    xfer(16, {16'h0, 2'b10, a, 8'h00}, rx);
    xfer(16, 32'h0, rx);
    v = rx[15:8];
    check(rx[7:0] == 8'h00, "R4 short zero fill", {24'h0, rx[7:0]}, 32'h0);
  endtask

  task automatic t_reset;
    check(err == 1'b0, "R12 flag at reset", {31'h0, err}, 32'h0);
    check(miso == 1'b0, "R12 miso at reset", {31'h0, miso}, 32'h0);
  endtask

  task automatic t_short_mode;
    logic [31:0] rx;
    logic [7:0] v;
    sread(6'd3, v);
    check(v == 8'h00, "R12 register reset value", {24'h0, v}, 32'h0);
    xfer(16, {16'h0, 2'b01, 6'd2, 8'h5A}, rx);
    sread(6'd2, v);
    check(v == 8'h5A, "R3 short write/read", {24'h0, v}, 32'h5A);
  endtask

  task automatic t_enable_crc;
    logic [31:0] rx;
    logic [7:0] v;
    xfer(16, {16'h0, 2'b01, 6'd1, 8'h01}, rx);
    lread(8'h01, 1'b0, v);
    check(v == 8'h01, "R10 crc mode enabled", {24'h0, v}, 32'h1);
    lread(8'h02, 1'b0, v);
    check(v == 8'h5A, "R4 long read of short-written reg", {24'h0, v}, 32'h5A);
  endtask

  task automatic t_long_write;
    logic [7:0] v;
    lwrite(8'h03, 8'hC3, 1'b0);
    lread(8'h03, 1'b0, v);
    check(v == 8'hC3, "R2 long write", {24'h0, v}, 32'hC3);
    check(err == 1'b0, "R2 no error on good crc", {31'h0, err}, 32'h0);
  endtask

  task automatic t_bad_crc;
    logic [7:0] v;
    lwrite(8'h03, 8'h11, 1'b1);
    check(err == 1'b1, "R5 flag set on mismatch", {31'h0, err}, 32'h1);
    lread(8'h03, 1'b0, v);
    check(v == 8'hC3, "R5 bad frame not executed / R7 read served", {24'h0, v}, 32'hC3);
  endtask

  task automatic t_locked;
    logic [7:0] v;
    lwrite(8'h03, 8'h22, 1'b0);
    lread(8'h03, 1'b0, v);
    check(v == 8'hC3, "R6 locked write ignored", {24'h0, v}, 32'hC3);
    lwrite(8'h00, 8'h00, 1'b0);
    check(err == 1'b1, "R6 status write of zero keeps flag", {31'h0, err}, 32'h1);
    lwrite(8'h01, 8'h00, 1'b0);
    lread(8'h01, 1'b0, v);
    check(v == 8'h01, "R6 locked config write ignored", {24'h0, v}, 32'h1);
    lread(8'h02, 1'b1, v);
    check(v == 8'h01, "R7 bad-crc read not served", {24'h0, v}, 32'h1);
    check(err == 1'b1, "R7 flag still set", {31'h0, err}, 32'h1);
    lread(8'h00, 1'b0, v);
    check(v == 8'h01, "R11 status shows flag", {24'h0, v}, 32'h1);
  endtask

  task automatic t_clear;
    logic [7:0] v;
    lwrite(8'h00, 8'h01, 1'b1);
    check(err == 1'b1, "R8 clear with bad crc refused", {31'h0, err}, 32'h1);
    lwrite(8'h00, 8'h01, 1'b0);
    check(err == 1'b0, "R8 flag cleared", {31'h0, err}, 32'h0);
    lwrite(8'h03, 8'h22, 1'b0);
    lread(8'h03, 1'b0, v);
    check(v == 8'h22, "R8 writes resume", {24'h0, v}, 32'h22);
    lread(8'h00, 1'b0, v);
    check(v == 8'h00, "R11 status clear", {24'h0, v}, 32'h0);
  endtask

  task automatic t_abort;
    logic [31:0] rx;
    logic [7:0] v;
    xfer(20, lf(8'h01, 8'h04, 8'h77, 1'b0) >> 12, rx);
    check(err == 1'b0, "R9 short abort no flag", {31'h0, err}, 32'h0);
    xfer(31, lf(8'h01, 8'h04, 8'h77, 1'b1) >> 1, rx);
    check(err == 1'b0, "R9 31-bit abort no flag", {31'h0, err}, 32'h0);
    lread(8'h04, 1'b0, v);
    check(v == 8'h00, "R9 aborted write discarded", {24'h0, v}, 32'h0);
  endtask

  task automatic t_disable;
    logic [31:0] rx;
    logic [7:0] v;
    lwrite(8'h01, 8'h00, 1'b0);
    xfer(16, {16'h0, 2'b01, 6'd5, 8'hA5}, rx);
    sread(6'd5, v);
    check(v == 8'hA5, "R10 back to short frames", {24'h0, v}, 32'hA5);
    check(err == 1'b0, "R10 no flag in short mode", {31'h0, err}, 32'h0);
  endtask

  initial begin
    waitn(5);
    rst_n = 1'b1;
    waitn(5);
    t_reset();
    t_short_mode();
    t_enable_crc();
    t_long_write();
    t_bad_crc();
    t_locked();
    t_clear();
    t_abort();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule